// File: doc/BRIEF.md
# Reset supervisor with watchdog

This synchronous block produces a system reset from three conditions: a supply-good flag delivered by an external comparator, an active-low manual reset request, and a keep-alive signal that the supervised system must keep toggling. Reset is raised at once when the supply flag drops. It is also raised when the manual request is held low, and for a fixed pulse when the keep-alive signal goes quiet for too long. After the supply returns or the manual request is let go, reset is held for a further delay before it releases.

The hold-off delay is chosen from two presets, a long one and a short one in a ratio of 200 to 25, each scaled by a cycles-per-unit parameter. The watchdog timeout is a separate cycle-count parameter. The manual request and the keep-alive input cross into the clock domain through two-flop synchronizers. The supply flag and the watchdog disable are taken as already synchronous. Reset is presented in three forms: active-low, active-high, and a pull-down enable for an open-drain style driver.

Top module: `rst_supervisor`

## Requirements
- R1: While the block reset `rst_n` is low at a clock edge, the outputs are reset-asserted (`rst_o`=1, `rst_n_o`=0, `od_pull`=1). With supply good and the manual request high, reset releases on the TD-th clock edge after `rst_n` is first sampled high.
- R2: While `supply_ok` is sampled low, reset stays asserted. After `supply_ok` rises, reset releases on the TD-th consecutive edge at which `supply_ok` is sampled high.
- R3: A low `supply_ok` sampled at any edge asserts reset at that same edge. This holds in the released state and also during the hold-off delay, where it restarts the full TD count.
- R4: `mr_n` driven low asserts reset on the third clock edge after the change (two synchronizer stages plus the reset register).
- R5: After `mr_n` returns high, with supply good, reset releases on edge TD+2 after the change.
- R6: Either a rising or a falling transition of `wdi` restarts the watchdog count. Transitions spaced at most TOUT cycles apart keep reset released.
- R7: Without `wdi` transitions, reset asserts TOUT+3 edges after the last transition. Measured from a release, it stays released for exactly TOUT cycles.
- R8: A watchdog timeout holds reset asserted for exactly TD cycles. After that, a fresh full TOUT interval passes before the next timeout.
- R9: While `wd_dis` is 1, the watchdog never asserts reset and its count stays at zero. After `wd_dis` falls, a timeout follows exactly TOUT cycles later.
- R10: `wdi` transitions made while reset is asserted are ignored. After release, the first timeout comes exactly TOUT cycles later.
- R11: The delay preset gives TD = 25*DELAY_UNIT for DLY_SHORT (enum value 0) and TD = 200*DELAY_UNIT for DLY_LONG (enum value 1).
- R12: At all times `rst_n_o` is the inverse of `rst_o`, and `od_pull` equals `rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | 1 | Supply above threshold (synchronous flag) |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog keep-alive, either edge counts, asynchronous |
| wd_dis | input | 1 | Watchdog disable, static |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| od_pull | output | 1 | Pull-down enable for an open-drain reset line |

## Verification
The supply path answers one edge after a change, the manual path three edges after, and a keep-alive transition takes effect three edges after it is driven. From there a timeout lands TOUT edges later, and each release lands TD edges after its cause clears. The bench drives inputs at falling clock edges and counts whole cycles from each stimulus. It samples one cycle before and exactly at each due edge, so an early or a late release both show up. Run lengths of reset-low and reset-high periods are counted sample by sample and compared with TOUT and TD, across every keep-alive spacing from 1 to TOUT and every supply-drop point inside the delay.

// File: rtl/rsup_pkg.sv
// Package: shared types and delay presets for the reset supervisor.
// Assumes a caller picks one preset and a cycles-per-unit scale.
package rsup_pkg;

    typedef enum logic {
        DLY_SHORT = 1'b0,
        DLY_LONG  = 1'b1
    } dly_sel_e;

    localparam int SHORT_UNITS = 25;
    localparam int LONG_UNITS  = 200;

    // Hold-off length in clock cycles for a preset and unit scale.
    function automatic int td_cycles(dly_sel_e sel, int unit);
        return ((sel == DLY_LONG) ? LONG_UNITS : SHORT_UNITS) * unit;
    endfunction

endpackage

// File: rtl/rsup_sync2.sv
// Module: two-flop synchronizer for a vector of independent async bits.
// Assumes each bit is a level signal; no bus coherence is implied.
module rsup_sync2 #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Shift the async inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= async_i;
            stage2 <= stage1;
        end
    end

    assign sync_o = stage2;
endmodule

// File: rtl/rsup_watchdog.sv
// Module: keep-alive timer. Either edge of the synchronized input clears
// the count; reaching TOUT_CYC cycles without an edge raises a one-cycle
// timeout. Assumes wdi_s is already synchronous and TOUT_CYC >= 2.
module rsup_watchdog #(
    parameter int TOUT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_s,
    input  logic hold_i,
    input  logic disable_i,
    output logic timeout_o
);
    localparam int CW = (TOUT_CYC > 2) ? $clog2(TOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TOUT_CYC - 1);

    logic          wdi_d;
    logic [CW-1:0] cnt;
    logic          edge_seen;

    assign edge_seen = wdi_s ^ wdi_d;
    assign timeout_o = !hold_i && !disable_i && !edge_seen && (cnt == LAST);

    // Track the previous input level and advance or clear the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdi_d <= 1'b0;
            cnt   <= '0;
        end else begin
            wdi_d <= wdi_s;
            if (hold_i || disable_i || edge_seen || timeout_o) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsup_delay.sv
// Module: reset register with hold-off counter. A hold request forces
// reset and clears the count. Once the request clears, reset stays
// asserted for TD_CYC cycles. A timeout in the released state starts an
// identical TD_CYC pulse. Assumes TD_CYC >= 2.
module rsup_delay #(
    parameter int TD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic fire_i,
    output logic rst_q
);
    localparam int CW = $clog2(TD_CYC);
    localparam logic [CW-1:0] LAST = CW'(TD_CYC - 1);

    logic [CW-1:0] cnt;

    // Hold, count down the hold-off, or arm a timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end else if (hold_req) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end else if (rst_q) begin
            if (cnt == LAST) begin
                rst_q <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (fire_i) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
// Module: reset supervisor top. Combines the supply flag, the synchronized
// manual request and the watchdog timeout into one registered reset, and
// drives it in three polarities. Assumes supply_ok and wd_dis are
// synchronous to clk; mr_n and wdi may be asynchronous.
module rst_supervisor #(
    parameter rsup_pkg::dly_sel_e DELAY_SEL  = rsup_pkg::DLY_LONG,
    parameter int                 DELAY_UNIT = 1,
    parameter int                 TOUT_CYC   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mr_n,
    input  logic wdi,
    input  logic wd_dis,
    output logic rst_n_o,
    output logic rst_o,
    output logic od_pull
);
    localparam int TD_CYC = rsup_pkg::td_cycles(DELAY_SEL, DELAY_UNIT);

    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       mr_s;
    logic       wdi_s;
    logic       rst_q;
    logic       wd_fire;
    logic       hold_req;

    assign async_in = {wdi, mr_n};

    rsup_sync2 #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_in),
        .sync_o  (sync_out)
    );

    assign mr_s     = sync_out[0];
    assign wdi_s    = sync_out[1];
    assign hold_req = !supply_ok || !mr_s;

    rsup_watchdog #(
        .TOUT_CYC (TOUT_CYC)
    ) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdi_s     (wdi_s),
        .hold_i    (rst_q),
        .disable_i (wd_dis),
        .timeout_o (wd_fire)
    );

    rsup_delay #(
        .TD_CYC (TD_CYC)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .fire_i   (wd_fire),
        .rst_q    (rst_q)
    );

    assign rst_o   = rst_q;
    assign rst_n_o = ~rst_q;
    assign od_pull = rst_q;
endmodule

// File: rtl/rst_supervisor_chk.sv
// Module: property checker for the reset supervisor, bound to every
// instance. Assumes the same TD_CYC as the instance it watches.
module rst_supervisor_chk #(
    parameter int TD_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic mr_n,
    input logic wd_dis,
    input logic rst_n_o,
    input logic rst_o
);
    localparam int HW = $clog2(TD_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(TD_CYC);

    logic [HW-1:0] hi_run;

    // Count consecutive cycles of good supply, saturating at TD_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            hi_run <= '0;
        end else if (hi_run != HMAX) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R3: a low supply sample forces reset at that edge.
    a_r3_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_o);

    // R2: no release before TD good-supply samples.
    a_r2_release_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> (hi_run == HMAX));

    // R4: manual request reaches reset after the synchronizer.
    a_r4_manual_assert: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |=> ##2 rst_o);

    // R9: reset rises only from supply, manual, or an enabled watchdog.
    a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> (!$past(supply_ok) || !$past(mr_n, 3) || !$past(wd_dis)));

    // R12: the two push-pull outputs stay complementary.
    a_r12_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o == !rst_o);
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .TD_CYC (TD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .mr_n      (mr_n),
    .wd_dis    (wd_dis),
    .rst_n_o   (rst_n_o),
    .rst_o     (rst_o)
);

// File: tb/tb_rst_supervisor.sv
// Bench: drives inputs on falling edges and checks reset timing by cycle
// counting against TD and TOUT derived from the parameters.
module tb_rst_supervisor;
    localparam int TD   = 25;
    localparam int TL   = 200;
    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mr_n, wdi, wd_dis;
    logic rst_n_o, rst_o, od_pull;
    logic l_rst_n_o, l_rst_o, l_od_pull;
    int   checks = 0;
    int   bad = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    rst_supervisor #(
        .DELAY_SEL (rsup_pkg::DLY_SHORT), .DELAY_UNIT (1), .TOUT_CYC (TOUT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .mr_n (mr_n),
        .wdi (wdi), .wd_dis (wd_dis),
        .rst_n_o (rst_n_o), .rst_o (rst_o), .od_pull (od_pull)
    );

    rst_supervisor #(
        .DELAY_SEL (rsup_pkg::DLY_LONG), .DELAY_UNIT (1), .TOUT_CYC (TOUT)
    ) dut_long (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .mr_n (mr_n),
        .wdi (wdi), .wd_dis (wd_dis),
        .rst_n_o (l_rst_n_o), .rst_o (l_rst_o), .od_pull (l_od_pull)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R12 output forms checked together with the level.
    task automatic chk_rst(string req, logic exp);
        chk(req, rst_o, exp);
        chk({req, "/R12 low"}, rst_n_o, ~exp);
        chk({req, "/R12 od"}, od_pull, exp);
    endtask

    task automatic run_len(logic lvl, output int n);
        n = 0;
        while (rst_o === lvl && n < 1000) begin
            n++;
            step(1);
        end
    endtask

    task automatic bring_up();
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(TD);
    endtask

    initial begin
        int n;
        rst_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1; wdi = 1'b0; wd_dis = 1'b1;
        step(3);
        chk_rst("R1 reset state", 1'b1);
        chk("R1 long reset state", l_rst_o, 1'b1);
        rst_n = 1'b1;
        step(TD - 1);
        chk("R1 held before TD", rst_o, 1'b1);
        step(1);
        chk_rst("R1 release at TD", 1'b0);
        step(TL - TD - 1);
        chk("R11 long held before 200", l_rst_o, 1'b1);
        step(1);
        chk("R11 long release at 200", l_rst_o, 1'b0);

        // R2: hold while low, then release after TD
        supply_ok = 1'b0;
        for (int i = 0; i < 100; i++) begin
            step(1);
            chk("R2 hold while supply low", rst_o, 1'b1);
        end
        supply_ok = 1'b1;
        step(TD - 1);
        chk("R2 held before TD", rst_o, 1'b1);
        step(1);
        chk_rst("R2 release at TD", 1'b0);

        // R3: immediate drop when released, and restart inside the delay
        supply_ok = 1'b0;
        step(1);
        chk_rst("R3 drop from released", 1'b1);
        for (int j = 1; j < TD; j++) begin
            supply_ok = 1'b1;
            step(j);
            chk("R3 in delay", rst_o, 1'b1);
            supply_ok = 1'b0;
            step(1);
            chk("R3 drop in delay", rst_o, 1'b1);
            supply_ok = 1'b1;
            step(TD - 1);
            chk("R3 restart held", rst_o, 1'b1);
            step(1);
            chk("R3 restart release", rst_o, 1'b0);
            supply_ok = 1'b0;
            step(1);
        end
        supply_ok = 1'b1;
        step(TD);
        chk("R3 final release", rst_o, 1'b0);

        // R4 / R5: manual request through the synchronizer
        mr_n = 1'b0;
        step(2);
        chk("R4 not yet at edge 2", rst_o, 1'b0);
        step(1);
        chk_rst("R4 asserted at edge 3", 1'b1);
        step(10);
        mr_n = 1'b1;
        step(TD + 1);
        chk("R5 held at TD+1", rst_o, 1'b1);
        step(1);
        chk("R5 release at TD+2", rst_o, 1'b0);

        // R9: disabled watchdog, then a timeout TOUT after enabling
        for (int i = 0; i < 500; i++) begin
            step(1);
            chk("R9 disabled no reset", rst_o, 1'b0);
        end
        wd_dis = 1'b0;
        run_len(1'b0, n);
        chk_int("R9 timeout after enable", n, TOUT);
        // R8: pulse length and fresh interval
        run_len(1'b1, n);
        chk_int("R8 pulse length", n, TD);
        run_len(1'b0, n);
        chk_int("R8 fresh interval", n, TOUT);

        // R6 / R7: every keep-alive spacing up to TOUT
        for (int p = 1; p <= TOUT; p++) begin
            bring_up();
            chk("R7 released before toggles", rst_o, 1'b0);
            for (int k = 0; k < 4; k++) begin
                wdi = ~wdi;
                for (int i = 0; i < p; i++) begin
                    step(1);
                    chk("R6 kept alive", rst_o, 1'b0);
                end
            end
            for (int i = 0; i < TOUT + 2 - p; i++) begin
                step(1);
                chk("R7 still released", rst_o, 1'b0);
            end
            step(1);
            chk("R7 timeout at TOUT+3", rst_o, 1'b1);
        end

        // R7 from release, R10 toggles during reset ignored
        supply_ok = 1'b0;
        for (int k = 0; k < 6; k++) begin
            wdi = ~wdi;
            step(3);
        end
        step(5);
        supply_ok = 1'b1;
        step(TD);
        chk("R10 release", rst_o, 1'b0);
        run_len(1'b0, n);
        chk_int("R10 interval after release", n, TOUT);
        run_len(1'b1, n);
        chk_int("R8 second pulse", n, TD);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule